// File: doc/BRIEF.md
# Debug-Link Data Register

This block is the 9-bit JTAG data register that sits between a TAP and the controller of a byte-wide debug link. Each frame carries one data byte and a parity bit. When the TAP passes through Capture-DR, the register loads one of three frames. If the link is sending and the controller has a byte waiting, it loads that byte with correct parity. If the link is receiving, it loads a fixed "empty" code. If the link is sending but no byte is ready yet, it loads a fixed "delay" code. The empty and delay frames carry a parity bit that is deliberately wrong, so the external debugger can tell them apart from real data.

In Shift-DR the frame moves out on TDO, least significant bit first, with the parity bit last. At the same time the bits on TDI move in. In Update-DR, while the link is receiving, the 8 received data bits go to the controller with a strobe and a parity-error flag. A byte that could not be sent at one capture stays pending on the handshake and is taken at a later capture, so it is not lost. Every register is clocked by TCK. The TAP state machine and instruction decode are outside the block: the state strobes arrive already qualified.

Top module: `dbg_link_dr`

## Requirements
- R1: At a capture edge with `txMode`=1 and `txValid`=1, the frame becomes `{^txData, txData}`, so the bit-8 parity is even over the data bits. `txReady` is 1 during that capture cycle, and the byte is transferred on that edge.
- R2: At a capture edge with `txMode`=0, the frame becomes `{1'b1, 8'hEB}`. 0xEB has even ones, so the parity bit is wrong on purpose.
- R3: At a capture edge with `txMode`=1 and `txValid`=0, the frame becomes `{1'b1, 8'hDB}` and `txReady` stays 0. A byte presented later stays pending until a capture accepts it.
- R4: Right after capture, `tdo` shows frame bit 0. Each rising TCK with `shiftDr`=1 advances one bit, so bit 8 (the parity bit) comes out ninth.
- R5: During shifting, the `tdi` bits enter at bit 8 and move down. After 9 shifts the register holds the 9 `tdi` bits, with the first one at bit 0.
- R6: An update edge with `txMode`=0 makes `rxStrobe` 1 for exactly one cycle. In that cycle `rxData` equals the first 8 received bits, and `rxParityErr` is 1 when the 9 received bits contain an odd number of ones.
- R7: An update edge with `txMode`=1 produces no `rxStrobe` and leaves `rxData` unchanged.
- R8: When `tlr`=1, the frame, `rxStrobe`, `rxData` and `rxParityErr` clear and `txReady` is 0. This holds even when `captureDr` is 1 on the same edge.
- R9: When none of capture, shift or reset is active, the register keeps its contents and `tdo` stays stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock; clocks every register |
| tlr | input | 1 | TAP is in Test-Logic-Reset (synchronous clear) |
| captureDr | input | 1 | TAP is in Capture-DR with this register selected |
| shiftDr | input | 1 | TAP is in Shift-DR with this register selected |
| updateDr | input | 1 | TAP is in Update-DR with this register selected |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out (frame bit 0) |
| txMode | input | 1 | 1: link is sending to the debugger, 0: link is receiving |
| txValid | input | 1 | Controller has a byte to send |
| txData | input | 8 | Byte to send |
| txReady | output | 1 | Byte taken at this capture edge |
| rxStrobe | output | 1 | One-cycle pulse: a received byte is valid |
| rxData | output | 8 | Received byte |
| rxParityErr | output | 1 | Received frame had odd parity |

## Verification
Two pairs of functions can land on the same TCK edge. The first pair is a capture and the controller's byte arriving. The bench raises `txValid` in the same cycle as `captureDr` and expects the real byte with `txReady`, not the delay code. The second pair is Test-Logic-Reset and a capture. The bench asserts both on one edge and then shifts out all nine bits, expecting zeros, which shows that reset took priority.

// File: rtl/dbg_link_pkg.sv
package dbg_link_pkg;
  typedef enum logic [1:0] {SRC_DATA, SRC_EMPTY, SRC_DELAY} frameSrc_e;

  typedef struct packed {
    logic      clear;
    logic      load;
    frameSrc_e src;
    logic      shift;
    logic      update;
  } drCtl_t;
endpackage

// File: rtl/dbg_link_dr_ctl.sv
module dbg_link_dr_ctl
  import dbg_link_pkg::*;
(
  input  logic   tlr,
  input  logic   captureDr,
  input  logic   shiftDr,
  input  logic   updateDr,
  input  logic   txMode,
  input  logic   txValid,
  output drCtl_t ctl,
  output logic   txReady
);
  always_comb begin
    ctl.clear  = tlr;
    ctl.load   = captureDr && !tlr;
    if (!txMode)      ctl.src = SRC_EMPTY;
    else if (txValid) ctl.src = SRC_DATA;
    else              ctl.src = SRC_DELAY;
    ctl.shift  = shiftDr && !tlr && !captureDr;
    ctl.update = updateDr && !tlr && !captureDr && !shiftDr && !txMode;
    txReady    = ctl.load && (ctl.src == SRC_DATA);
  end
endmodule

// File: rtl/dbg_link_dr_dp.sv
module dbg_link_dr_dp
  import dbg_link_pkg::*;
#(
  parameter int                DATA_W     = 8,
  parameter logic [DATA_W-1:0] EMPTY_CODE = 8'hEB,
  parameter logic [DATA_W-1:0] DELAY_CODE = 8'hDB
) (
  input  logic              tck,
  input  drCtl_t            ctl,
  input  logic              tdi,
  input  logic [DATA_W-1:0] txData,
  output logic              tdo,
  output logic              rxStrobe,
  output logic [DATA_W-1:0] rxData,
  output logic              rxParityErr
);
  localparam int FRAME_W = DATA_W + 1;

  logic [FRAME_W-1:0] shiftReg;
  logic [FRAME_W-1:0] loadFrame;

  // Marker frames carry inverted parity so the far end sees an error.
  always_comb begin
    case (ctl.src)
      SRC_DATA:  loadFrame = {^txData, txData};
      SRC_EMPTY: loadFrame = {~(^EMPTY_CODE), EMPTY_CODE};
      default:   loadFrame = {~(^DELAY_CODE), DELAY_CODE};
    endcase
  end

  always_ff @(posedge tck) begin
    if (ctl.clear)      shiftReg <= '0;
    else if (ctl.load)  shiftReg <= loadFrame;
    else if (ctl.shift) shiftReg <= {tdi, shiftReg[FRAME_W-1:1]};
  end

  always_ff @(posedge tck) begin
    if (ctl.clear) begin
      rxStrobe    <= 1'b0;
      rxData      <= '0;
      rxParityErr <= 1'b0;
    end else begin
      rxStrobe <= ctl.update;
      if (ctl.update) begin
        rxData      <= shiftReg[DATA_W-1:0];
        rxParityErr <= ^shiftReg;
      end
    end
  end

  assign tdo = shiftReg[0];
endmodule

// File: rtl/dbg_link_dr.sv
module dbg_link_dr
  import dbg_link_pkg::*;
#(
  parameter int                DATA_W     = 8,
  parameter logic [DATA_W-1:0] EMPTY_CODE = 8'hEB,
  parameter logic [DATA_W-1:0] DELAY_CODE = 8'hDB
) (
  input  logic              tck,
  input  logic              tlr,
  input  logic              captureDr,
  input  logic              shiftDr,
  input  logic              updateDr,
  input  logic              tdi,
  output logic              tdo,
  input  logic              txMode,
  input  logic              txValid,
  input  logic [DATA_W-1:0] txData,
  output logic              txReady,
  output logic              rxStrobe,
  output logic [DATA_W-1:0] rxData,
  output logic              rxParityErr
);
  drCtl_t ctl;

  dbg_link_dr_ctl u_ctl (
    .tlr(tlr), .captureDr(captureDr), .shiftDr(shiftDr), .updateDr(updateDr),
    .txMode(txMode), .txValid(txValid), .ctl(ctl), .txReady(txReady)
  );

  dbg_link_dr_dp #(.DATA_W(DATA_W), .EMPTY_CODE(EMPTY_CODE), .DELAY_CODE(DELAY_CODE)) u_dp (
    .tck(tck), .ctl(ctl), .tdi(tdi), .txData(txData), .tdo(tdo),
    .rxStrobe(rxStrobe), .rxData(rxData), .rxParityErr(rxParityErr)
  );
endmodule

// File: rtl/dbg_link_dr_chk.sv
module dbg_link_dr_chk #(
  parameter int DATA_W = 8
) (
  input logic              tck,
  input logic              tlr,
  input logic              captureDr,
  input logic              shiftDr,
  input logic              updateDr,
  input logic              tdo,
  input logic              txMode,
  input logic              txValid,
  input logic [DATA_W-1:0] txData,
  input logic              txReady,
  input logic              rxStrobe,
  input logic [DATA_W-1:0] rxData,
  input logic              rxParityErr
);
  assert_accept_data_R1: assert property (@(posedge tck) disable iff (tlr)
    txReady |=> tdo == $past(txData[0]));

  assert_marker_lsb_R2: assert property (@(posedge tck) disable iff (tlr)
    (captureDr && !txMode) |=> tdo);

  assert_delay_no_ack_R3: assert property (@(posedge tck) disable iff (tlr)
    (captureDr && txMode && !txValid) |-> (!txReady ##1 tdo));

  assert_rx_pulse_R6: assert property (@(posedge tck) disable iff (tlr)
    rxStrobe |-> ($past(updateDr) && $past(!txMode)));

  assert_rx_single_R6: assert property (@(posedge tck) disable iff (tlr)
    rxStrobe |=> !rxStrobe);

  assert_tx_update_quiet_R7: assert property (@(posedge tck) disable iff (tlr)
    (updateDr && txMode) |=> (!rxStrobe && $stable(rxData)));

  assert_reset_clear_R8: assert property (@(posedge tck)
    tlr |=> (!tdo && !rxStrobe && rxData == '0 && !rxParityErr));

  assert_reset_no_ack_R8: assert property (@(posedge tck)
    tlr |-> !txReady);

  assert_idle_hold_R9: assert property (@(posedge tck) disable iff (tlr)
    (!captureDr && !shiftDr) |=> $stable(tdo));
endmodule

bind dbg_link_dr dbg_link_dr_chk #(.DATA_W(DATA_W)) u_chk (
  .tck(tck), .tlr(tlr), .captureDr(captureDr), .shiftDr(shiftDr),
  .updateDr(updateDr), .tdo(tdo), .txMode(txMode), .txValid(txValid),
  .txData(txData), .txReady(txReady), .rxStrobe(rxStrobe), .rxData(rxData),
  .rxParityErr(rxParityErr)
);

// File: tb/dbg_link_dr_test.sv
module dbg_link_dr_test;
  logic       tck = 1'b0;
  logic       tlr = 1'b1;
  logic       captureDr = 1'b0, shiftDr = 1'b0, updateDr = 1'b0, tdi = 1'b0;
  logic       txMode = 1'b0, txValid = 1'b0;
  logic [7:0] txData = 8'h00;
  logic       tdo, txReady, rxStrobe, rxParityErr;
  logic [7:0] rxData;
  int         checks = 0;
  int         errors = 0;
  bit         done = 1'b0;

  always #4 tck = ~tck;

  dbg_link_dr uut (
    .tck(tck), .tlr(tlr), .captureDr(captureDr), .shiftDr(shiftDr),
    .updateDr(updateDr), .tdi(tdi), .tdo(tdo), .txMode(txMode),
    .txValid(txValid), .txData(txData), .txReady(txReady),
    .rxStrobe(rxStrobe), .rxData(rxData), .rxParityErr(rxParityErr)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Drive a capture edge. txReady is checked before the edge.
  task automatic capture(input logic mode, input logic valid, input logic [7:0] data,
                         input logic expReady, input string req);
    txMode = mode; txValid = valid; txData = data; captureDr = 1'b1;
    #1 check(req, txReady, expReady);
    @(posedge tck); @(negedge tck);
    captureDr = 1'b0; txValid = 1'b0;
  endtask

  // Shift nine bits, returning what appeared on tdo.
  task automatic shiftFrame(input logic [8:0] inBits, output logic [8:0] outBits);
    for (int i = 0; i < 9; i++) begin
      outBits[i] = tdo;
      tdi = inBits[i]; shiftDr = 1'b1;
      @(posedge tck); @(negedge tck);
    end
    shiftDr = 1'b0; tdi = 1'b0;
  endtask

  task automatic update(input logic mode);
    txMode = mode; updateDr = 1'b1;
    @(posedge tck); @(negedge tck);
    updateDr = 1'b0;
  endtask

  task automatic testReset();
    check("R8 reset tdo", tdo, 0);
    check("R8 reset rxStrobe", rxStrobe, 0);
    check("R8 reset rxData", rxData, 0);
    check("R8 reset rxParityErr", rxParityErr, 0);
    check("R8 reset txReady", txReady, 0);
  endtask

  task automatic testEmpty();
    logic [8:0] got;
    capture(1'b0, 1'b1, 8'h55, 1'b0, "R2 no ack in rx");
    shiftFrame(9'h000, got);
    check("R2 empty frame", got, 9'h1EB);
  endtask

  task automatic testData(input logic [7:0] d);
    logic [8:0] got;
    capture(1'b1, 1'b1, d, 1'b1, "R1 ack");
    shiftFrame(9'h000, got);
    check("R1 R4 data frame", got, {^d, d});
  endtask

  task automatic testPending();
    logic [8:0] got;
    capture(1'b1, 1'b0, 8'h00, 1'b0, "R3 no ack when not ready");
    shiftFrame(9'h000, got);
    check("R3 delay frame", got, 9'h1DB);
    capture(1'b1, 1'b1, 8'h9C, 1'b1, "R3 pending byte acked");
    shiftFrame(9'h000, got);
    check("R3 pending byte sent", got, {^8'h9C, 8'h9C});
  endtask

  task automatic testReceive(input logic [8:0] frame);
    logic [8:0] got;
    capture(1'b0, 1'b0, 8'h00, 1'b0, "R6 rx capture");
    shiftFrame(frame, got);
    check("R5 tdi lsb now on tdo", tdo, frame[0]);
    update(1'b0);
    check("R6 strobe", rxStrobe, 1);
    check("R6 data", rxData, frame[7:0]);
    check("R6 parity flag", rxParityErr, ^frame);
    @(posedge tck); @(negedge tck);
    check("R6 strobe single", rxStrobe, 0);
  endtask

  task automatic testTxUpdate();
    logic [8:0] got;
    logic [7:0] prev = rxData;
    capture(1'b1, 1'b1, 8'h11, 1'b1, "R7 tx capture");
    shiftFrame(9'h0F0, got);
    update(1'b1);
    check("R7 no strobe", rxStrobe, 0);
    check("R7 data held", rxData, prev);
  endtask

  task automatic testHold();
    logic [8:0] got;
    capture(1'b1, 1'b1, 8'hC3, 1'b1, "R9 capture");
    repeat (3) begin
      @(posedge tck); @(negedge tck);
      check("R9 tdo held", tdo, 1);
    end
    shiftFrame(9'h000, got);
    check("R9 frame intact", got, {^8'hC3, 8'hC3});
  endtask

  task automatic testResetWins();
    logic [8:0] got;
    tlr = 1'b1;
    capture(1'b0, 1'b0, 8'h00, 1'b0, "R8 no ack in reset");
    tlr = 1'b0;
    shiftFrame(9'h000, got);
    check("R8 reset beats capture", got, 9'h000);
  endtask

  initial begin
    repeat (3) @(negedge tck);
    testReset();
    tlr = 1'b0;
    @(negedge tck);
    testEmpty();
    testData(8'hA5);
    testData(8'h07);
    testPending();
    testReceive(9'h03C);
    testReceive(9'h001);
    testReceive(9'h1FF);
    testTxUpdate();
    testHold();
    testResetWins();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule